// File: doc/BRIEF.md
# Spindle Start and Fault Supervisor

This block sequences the start and stop of a brushless spindle drive and guards it against two failures: a rotor that stops turning and a reference clock that goes missing. It watches a level start/stop request, a slow timebase tick, single-cycle pulses marking reference clock edges, and single-cycle pulses marking tachometer edges of one polarity. From these it drives a drive-enable, a flag for intermittent drive, a reset for the rest of the speed controller, and a latched stall fault.

Starting always passes through a reset phase of a configurable number of ticks. Only after that phase ends is drive enabled. In run, two tick counters are active. One counts ticks since the last tachometer edge. The other counts ticks since the last reference edge. A lost reference clock moves the block to a pulsed drive mode, and a later reference edge brings it back to normal control. A stalled rotor moves it to a fault state that only a stop request clears. A force-off input stands for thermal or supply protection. It blanks drive while it is asserted and changes nothing else.

Top module: `spindle_supervisor`

## Requirements
- R1: While `start_n` is 1 (1 = stop, 0 = start), the state moves to STOP on the next clock from any state. In STOP, `drive_en`=0, `intermittent`=0, `stall_fault`=0 and `logic_rst`=1. There is no braking output.
- R2: With `start_n` at 0, STOP moves to RESET. RESET holds `logic_rst`=1 and `drive_en`=0 for INIT_TICKS ticks, and INIT_TICKS is never taken below 1. The tick that completes the count moves the state to RUN, where `logic_rst`=0 and `drive_en`=1.
- R3: In RUN or INTERMITTENT, if STALL_TICKS ticks (default 31) arrive with no tachometer edge, the state moves to FAULT on the last of them. FAULT gives `stall_fault`=1 and `drive_en`=0.
- R4: Every tachometer edge restarts the stall count. A tachometer edge in the same cycle as a tick counts as a restart, and that tick is not counted.
- R5: FAULT is left only when `start_n` goes to 1. Reference edges, tachometer edges and ticks leave it unchanged.
- R6: In RUN, if REF_TICKS ticks (default 2) arrive with no reference edge, the state moves to INTERMITTENT, with `intermittent`=1. A reference edge in the same cycle as a tick restarts the window.
- R7: In INTERMITTENT, drive is off for the first tick interval and then toggles on every tick.
- R8: A reference edge in INTERMITTENT, before the stall timeout, moves the state back to RUN with continuous drive.
- R9: `force_off`=1 holds `drive_en` at 0 in the same cycle. It changes neither the state nor the stall latch.
- R10: `state_onehot` has exactly one bit set. The bit order is STOP=bit0, RESET=bit1, RUN=bit2, INTERMITTENT=bit3 and FAULT=bit4.
- R11: After power-on reset (`rst_n`=0), the state is STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low |
| start_n | input | 1 | Start/stop level: 0 = start, 1 = stop |
| tick | input | 1 | One-cycle timebase tick |
| ref_edge | input | 1 | One-cycle pulse on each reference clock edge |
| tach_edge | input | 1 | One-cycle pulse on each tachometer edge of one polarity |
| force_off | input | 1 | Protection force-off, blanks drive |
| drive_en | output | 1 | Drive enable |
| intermittent | output | 1 | High while in pulsed drive mode |
| logic_rst | output | 1 | Reset for the downstream speed controller |
| stall_fault | output | 1 | Latched stalled-rotor fault |
| state_onehot | output | 5 | One-hot state, for observation |

## Verification
The bench places a tachometer edge on the exact tick that would otherwise complete the stall window. A design that counts that tick instead of restarting faults one interval early. It then counts a full window after each restart, so an off-by-one limit shows up as a fault that comes too early or too late. It starts with the reference clock absent and tries two return times: one inside the stall window, which must restore run, and one after it, which must leave the fault in place. Force-off is held through many ticks with the rotor turning, so that a design which latches the fault from protection, or which frees drive late, is caught. A stop request during the reset phase shows whether the reset length can be cut short or ignored.

// File: rtl/spindle_sup_pkg.sv
package spindle_sup_pkg;

    typedef enum logic [2:0] {
        ST_STOP  = 3'd0,
        ST_INIT  = 3'd1,
        ST_RUN   = 3'd2,
        ST_PULSE = 3'd3,
        ST_FAULT = 3'd4
    } sup_state_e;

    localparam int unsigned N_STATES = 5;

    typedef struct packed {
        sup_state_e st;
        logic       phase;
    } sup_reg_t;

endpackage

// File: rtl/tick_window_cnt.sv
module tick_window_cnt #(
    parameter int unsigned LIMIT = 31
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic hit
);
    localparam int unsigned LIM_EFF = (LIMIT < 1) ? 1 : LIMIT;
    localparam int unsigned W       = $clog2(LIM_EFF + 1);
    localparam logic [W-1:0] LAST   = W'(LIM_EFF - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        hit   = tick && !clr && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = hit ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/spindle_out_decode.sv
module spindle_out_decode
    import spindle_sup_pkg::*;
(
    input  sup_state_e             st,
    input  logic                   phase,
    input  logic                   force_off,
    output logic                   drive_en,
    output logic                   intermittent,
    output logic                   logic_rst,
    output logic                   stall_fault,
    output logic [N_STATES-1:0]    state_onehot
);
    always_comb begin
        state_onehot = '0;
        for (int i = 0; i < int'(N_STATES); i++) begin
            state_onehot[i] = (st == sup_state_e'(i));
        end
        intermittent = (st == ST_PULSE);
        logic_rst    = (st == ST_STOP) || (st == ST_INIT);
        stall_fault  = (st == ST_FAULT);
        drive_en     = !force_off &&
                       ((st == ST_RUN) || ((st == ST_PULSE) && phase));
    end

endmodule

// File: rtl/spindle_supervisor.sv
module spindle_supervisor
    import spindle_sup_pkg::*;
#(
    parameter int unsigned INIT_TICKS  = 2,
    parameter int unsigned STALL_TICKS = 31,
    parameter int unsigned REF_TICKS   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_n,
    input  logic       tick,
    input  logic       ref_edge,
    input  logic       tach_edge,
    input  logic       force_off,
    output logic       drive_en,
    output logic       intermittent,
    output logic       logic_rst,
    output logic       stall_fault,
    output logic [4:0] state_onehot
);
    localparam int unsigned INIT_EFF = (INIT_TICKS < 1) ? 1 : INIT_TICKS;

    sup_reg_t r_d, r_q;

    logic init_clr, init_hit;
    logic stall_clr, stall_hit;
    logic ref_clr, ref_hit;
    logic spinning;

    assign spinning  = (r_q.st == ST_RUN) || (r_q.st == ST_PULSE);
    assign init_clr  = (r_q.st != ST_INIT) || start_n;
    assign stall_clr = !spinning || tach_edge || start_n;
    assign ref_clr   = (r_q.st != ST_RUN) || ref_edge || start_n;

    tick_window_cnt #(.LIMIT(INIT_EFF)) u_init_cnt (
        .clk(clk), .rst_n(rst_n), .clr(init_clr), .tick(tick), .hit(init_hit)
    );

    tick_window_cnt #(.LIMIT(STALL_TICKS)) u_stall_cnt (
        .clk(clk), .rst_n(rst_n), .clr(stall_clr), .tick(tick), .hit(stall_hit)
    );

    tick_window_cnt #(.LIMIT(REF_TICKS)) u_ref_cnt (
        .clk(clk), .rst_n(rst_n), .clr(ref_clr), .tick(tick), .hit(ref_hit)
    );

    always_comb begin
        r_d = r_q;
        if (start_n) begin
            r_d.st = ST_STOP;
        end else begin
            unique case (r_q.st)
                ST_STOP:  r_d.st = ST_INIT;
                ST_INIT:  if (init_hit) r_d.st = ST_RUN;
                ST_RUN: begin
                    if (stall_hit)    r_d.st = ST_FAULT;
                    else if (ref_hit) r_d.st = ST_PULSE;
                end
                ST_PULSE: begin
                    if (stall_hit)     r_d.st = ST_FAULT;
                    else if (ref_edge) r_d.st = ST_RUN;
                end
                ST_FAULT: r_d.st = ST_FAULT;
                default:  r_d.st = ST_STOP;
            endcase
        end
        if (r_q.st == ST_PULSE && tick) r_d.phase = !r_q.phase;
        else if (r_q.st != ST_PULSE)    r_d.phase = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_STOP, phase: 1'b0};
        else        r_q <= r_d;
    end

    spindle_out_decode u_dec (
        .st(r_q.st), .phase(r_q.phase), .force_off(force_off),
        .drive_en(drive_en), .intermittent(intermittent),
        .logic_rst(logic_rst), .stall_fault(stall_fault),
        .state_onehot(state_onehot)
    );

endmodule

// File: rtl/spindle_supervisor_chk.sv
module spindle_supervisor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_n,
    input logic       tick,
    input logic       ref_edge,
    input logic       force_off,
    input logic       drive_en,
    input logic       intermittent,
    input logic       logic_rst,
    input logic       stall_fault,
    input logic [4:0] state_onehot
);
    a_r1_stop_follows: assert property (@(posedge clk) disable iff (!rst_n)
        start_n |=> state_onehot[0]);

    a_r1_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        state_onehot[0] |-> (!drive_en && !stall_fault && !intermittent));

    a_r2_reset_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        logic_rst |-> !drive_en);

    a_r3_fault_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        stall_fault |-> !drive_en);

    a_r5_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_fault && !start_n) |=> stall_fault);

    a_r6_enter_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intermittent) |-> $past(tick));

    a_r8_leave_on_ref: assert property (@(posedge clk) disable iff (!rst_n)
        (intermittent && ref_edge) |=> !intermittent);

    a_r9_force_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        force_off |-> !drive_en);

    a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_onehot) == 1);

endmodule

bind spindle_supervisor spindle_supervisor_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .tick(tick),
    .ref_edge(ref_edge), .force_off(force_off), .drive_en(drive_en),
    .intermittent(intermittent), .logic_rst(logic_rst),
    .stall_fault(stall_fault), .state_onehot(state_onehot)
);

// File: tb/tb_spindle_supervisor.sv
module tb_spindle_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int STALL = 31;
    localparam int INIT  = 2;

    localparam logic [4:0] S_STOP = 5'b00001, S_INIT = 5'b00010, S_RUN = 5'b00100,
                           S_PULSE = 5'b01000, S_FAULT = 5'b10000;

    // {start_n,tick,ref,tach,force} | {drive,inter,lrst,fault} | state
    localparam int NV = 11;
    localparam logic [13:0] VEC [NV] = '{
        {5'b10000, 4'b0010, 5'b00001},
        {5'b00000, 4'b0010, 5'b00010},
        {5'b01000, 4'b0010, 5'b00010},
        {5'b01000, 4'b1000, 5'b00100},
        {5'b00110, 4'b1000, 5'b00100},
        {5'b00001, 4'b0000, 5'b00100},
        {5'b01000, 4'b1000, 5'b00100},
        {5'b01000, 4'b0100, 5'b01000},
        {5'b01000, 4'b1100, 5'b01000},
        {5'b00100, 4'b1000, 5'b00100},
        {5'b10000, 4'b0010, 5'b00001}
    };

    logic clk = 0, rst_n = 0;
    logic start_n = 1, tick = 0, ref_edge = 0, tach_edge = 0, force_off = 0;
    logic drive_en, intermittent, logic_rst, stall_fault;
    logic [4:0] state_onehot;
    logic [3:0] obs;
    logic [4:0] st_obs;
    int total = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spindle_supervisor dut (
        .clk(clk), .rst_n(rst_n), .start_n(start_n), .tick(tick),
        .ref_edge(ref_edge), .tach_edge(tach_edge), .force_off(force_off),
        .drive_en(drive_en), .intermittent(intermittent), .logic_rst(logic_rst),
        .stall_fault(stall_fault), .state_onehot(state_onehot)
    );

    task automatic summary();
        $display("  %0d/%0d checks passed", total - fails, total);
    endtask

    task automatic sample();
        obs    = {drive_en, intermittent, logic_rst, stall_fault};
        st_obs = state_onehot;
    endtask

    task automatic cyc(input logic sn, tk, rf, tc, fo);
        start_n = sn; tick = tk; ref_edge = rf; tach_edge = tc; force_off = fo;
        @(posedge clk);
        #(CLK_PERIOD/4);
        sample();
        tick = 0; ref_edge = 0; tach_edge = 0;
    endtask

    task automatic chk(input string tag, input logic [3:0] exp_o, input logic [4:0] exp_s);
        total++;
        if (obs !== exp_o || st_obs !== exp_s) begin
            fails++;
            $display("FAIL %s: outputs=%b state=%b expected outputs=%b state=%b",
                     tag, obs, st_obs, exp_o, exp_s);
        end
    endtask

    task automatic go_run();
        cyc(1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        for (int i = 0; i < INIT; i++) cyc(0, 1, 1, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: run did not complete, expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        sample();
        chk("R11 in reset", 4'b0010, S_STOP);
        rst_n = 1;
        cyc(1, 0, 0, 0, 0);
        chk("R11 after reset", 4'b0010, S_STOP);

        // vector table: R2 R6 R7 R8 R9 R10
        for (int v = 0; v < NV; v++) begin
            cyc(VEC[v][13], VEC[v][12], VEC[v][11], VEC[v][10], VEC[v][9]);
            chk($sformatf("table R2 R6 R7 R8 R10 row %0d", v), VEC[v][8:5], VEC[v][4:0]);
        end

        // R2 reset length and R1 stop during reset
        cyc(0, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0);
        chk("R2 reset held after one tick", 4'b0010, S_INIT);
        cyc(1, 1, 0, 0, 0);
        chk("R1 stop during reset", 4'b0010, S_STOP);

        // R3 stall timeout exact, R5 latch, R1 clear
        go_run();
        chk("R2 run after init", 4'b1000, S_RUN);
        for (int i = 0; i < STALL - 1; i++) cyc(0, 1, 1, 0, 0);
        chk("R3 no fault one tick early", 4'b1000, S_RUN);
        cyc(0, 1, 1, 0, 0);
        chk("R3 fault at timeout", 4'b0001, S_FAULT);
        cyc(0, 1, 1, 1, 0);
        chk("R5 fault holds on edges", 4'b0001, S_FAULT);
        cyc(0, 0, 0, 1, 1);
        chk("R5 fault holds", 4'b0001, S_FAULT);
        cyc(1, 0, 0, 0, 0);
        chk("R1 stop clears fault", 4'b0010, S_STOP);

        // R4 restart on coincident tach and tick
        go_run();
        for (int i = 0; i < STALL - 1; i++) cyc(0, 1, 1, 0, 0);
        cyc(0, 1, 1, 1, 0);
        chk("R4 coincident tach restarts", 4'b1000, S_RUN);
        for (int i = 0; i < STALL - 1; i++) cyc(0, 1, 1, 0, 0);
        chk("R4 full window after restart", 4'b1000, S_RUN);
        cyc(0, 1, 1, 0, 0);
        chk("R4 fault after restarted window", 4'b0001, S_FAULT);

        // R6 R7 R8: clock missing at start, returns in time
        go_run();
        cyc(0, 1, 0, 0, 0);
        chk("R6 one quiet tick still run", 4'b1000, S_RUN);
        cyc(0, 1, 0, 0, 0);
        chk("R6 enter intermittent", 4'b0100, S_PULSE);
        cyc(0, 1, 0, 0, 0);
        chk("R7 pulse on", 4'b1100, S_PULSE);
        cyc(0, 1, 0, 0, 0);
        chk("R7 pulse off", 4'b0100, S_PULSE);
        cyc(0, 1, 0, 0, 1);
        chk("R9 force blanks pulse", 4'b0100, S_PULSE);
        cyc(0, 0, 0, 0, 0);
        chk("R7 pulse on after force", 4'b1100, S_PULSE);
        cyc(0, 0, 1, 0, 0);
        chk("R8 clock returns", 4'b1000, S_RUN);

        // clock absent beyond stall timeout
        go_run();
        for (int i = 0; i < STALL - 1; i++) cyc(0, 1, 0, 0, 0);
        chk("R3 intermittent before timeout", {st_obs == S_PULSE ? obs[3] : 1'b0, 3'b100}, S_PULSE);
        cyc(0, 1, 0, 0, 0);
        chk("R3 fault from intermittent", 4'b0001, S_FAULT);
        cyc(0, 0, 1, 0, 0);
        chk("R5 late clock keeps fault", 4'b0001, S_FAULT);

        // R9 force-off does not latch
        go_run();
        for (int i = 0; i < STALL + 9; i++) cyc(0, 1, 1, 1, 1);
        chk("R9 forced off no fault", 4'b0000, S_RUN);
        cyc(0, 0, 0, 0, 0);
        chk("R9 drive returns", 4'b1000, S_RUN);
        cyc(1, 0, 0, 0, 0);
        chk("R1 final stop", 4'b0010, S_STOP);

        summary();
        $finish;
    end
endmodule